// File: doc/BRIEF.md
# Two-Source Vector Byte Permute Unit

This block builds a 128-bit result vector out of bytes taken freely from two 128-bit source vectors. A third 128-bit operand, the selector vector, holds one selector byte for each result byte. The low five bits of a selector byte name one of the 32 source bytes, and that byte is copied into the matching result position. Each position is selected on its own. A source byte may therefore appear in many positions or in none. Interleaves, merges, reversals, broadcasts and table lookups are all produced by choosing a suitable selector vector.

All four operands are separate ports, so neither source is overwritten by the result. The result is registered. It appears one clock after a cycle in which `in_valid` is high, and `out_valid` marks that cycle. When `in_valid` is low the result register keeps its value.

Top module: `byte_permute_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first accepted operation, `result` is all zeros and `out_valid` is 0.
- R2: `out_valid` is high in exactly the cycles that follow a rising clock edge at which `in_valid` was high. The result of an operation accepted at edge N is visible after edge N+1 (one cycle of latency).
- R3: Byte p of a vector occupies bits [127-8p : 120-8p], so byte 0 is the most significant byte. A selector value v in 0..15 places byte v of `src_a` into result byte p.
- R4: A selector value v in 16..31 places byte v-16 of `src_b` into result byte p.
- R5: Only bits [4:0] of each selector byte are used. Bits [7:5] have no effect on the result.
- R6: The selector vector whose byte p holds the value p, for p = 0..15, reproduces `src_a` exactly.
- R7: In a cycle where `in_valid` is low, `result` keeps its previous value whatever `src_a`, `src_b` and `sel_vec` carry.
- R8: Each result byte is selected independently of the others. The same source byte may fill several positions, and all 16 positions may take the same byte (broadcast).
- R9: Byte interleave of the first halves of the two sources (selector p = p/2 for even p, and 16 + p/2 for odd p) and a half/half merge (selector p = p for p < 8, and 16 + p for p >= 8) produce the expected mixed vectors.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| src_a | input | 128 | First source vector, byte indices 0..15 |
| src_b | input | 128 | Second source vector, byte indices 16..31 |
| sel_vec | input | 128 | One selector byte per result position |
| in_valid | input | 1 | Accept the operands at this edge |
| result | output | 128 | Registered permuted vector |
| out_valid | output | 1 | The result of an accepted operation is present |

## Verification
Every selector value from 0 to 31 is applied as a broadcast to all 16 positions. This shows that each value reaches the correct byte of the correct source, and it separates errors in the A/B split from errors in the byte order. A second sweep rotates the selector values across the positions, so that every position sees every value with different neighbours. This catches lanes that are wired to the wrong selector byte. The identity, interleave and merge vectors are applied with randomised high selector bits to show that those bits are ignored. A stimulus with `in_valid` low and changed operands shows that the held result and `out_valid` do not move.

// File: rtl/bperm_pkg.sv
// Shared sizing for the byte permute unit.
// Assumes: the number of lanes is a power of two and each source has the same lane count.
package bperm_pkg;
    localparam int LANES   = 16;
    localparam int LANE_W  = 8;
    localparam int VEC_W   = LANES * LANE_W;
    localparam int POOL_N  = 2 * LANES;
    localparam int IDX_W   = $clog2(POOL_N);
    localparam int HALF_W  = $clog2(LANES);
endpackage

// File: rtl/bperm_lane_sel.sv
// One result lane: picks one byte out of the pool of both sources.
// The pool is ordered with source A lanes first, then source B lanes.
// Assumes: the top bit of the index chooses the source and the remaining bits choose the lane.
module bperm_lane_sel #(
    parameter int LANES  = 16,
    parameter int LANE_W = 8,
    parameter int IDX_W  = $clog2(2 * LANES)
) (
    input  logic [2*LANES-1:0][LANE_W-1:0] pool,
    input  logic [LANE_W-1:0]              sel_byte,
    output logic [LANE_W-1:0]              lane_out
);
    localparam int HALF_W = IDX_W - 1;

    logic [IDX_W-1:0]  idx;
    logic [LANE_W-1:0] pick_a;
    logic [LANE_W-1:0] pick_b;
    logic              unused_sel_hi;

    // Split the selector into a source choice and a lane index; bits above it are dropped.
    always_comb begin
        idx           = sel_byte[IDX_W-1:0];
        unused_sel_hi = ^sel_byte[LANE_W-1:IDX_W];
    end

    // Choose the lane within each source, then choose the source.
    always_comb begin
        pick_a   = pool[{1'b0, idx[HALF_W-1:0]}];
        pick_b   = pool[{1'b1, idx[HALF_W-1:0]}];
        lane_out = idx[IDX_W-1] ? pick_b : pick_a;
    end
endmodule

// File: rtl/bperm_xbar.sv
// Full crossbar: unpacks both sources into a byte pool and gives every result lane its own selector.
// Assumes: byte 0 of every vector is its most significant byte.
module bperm_xbar #(
    parameter int LANES  = 16,
    parameter int LANE_W = 8
) (
    input  logic [LANES*LANE_W-1:0] src_a,
    input  logic [LANES*LANE_W-1:0] src_b,
    input  logic [LANES*LANE_W-1:0] sel_vec,
    output logic [LANES*LANE_W-1:0] perm_out
);
    localparam int VEC_W = LANES * LANE_W;
    localparam int IDX_W = $clog2(2 * LANES);

    logic [2*LANES-1:0][LANE_W-1:0] pool;

    genvar k;
    generate
        for (k = 0; k < LANES; k++) begin : g_lane
            logic [LANE_W-1:0] sel_k;
            logic [LANE_W-1:0] out_k;

            // Place source bytes into the pool in index order, byte 0 taken from the top bits.
            always_comb begin
                pool[k]         = src_a[VEC_W-1-k*LANE_W -: LANE_W];
                pool[LANES + k] = src_b[VEC_W-1-k*LANE_W -: LANE_W];
                sel_k           = sel_vec[VEC_W-1-k*LANE_W -: LANE_W];
            end

            bperm_lane_sel #(
                .LANES  (LANES),
                .LANE_W (LANE_W),
                .IDX_W  (IDX_W)
            ) lane_i (
                .pool     (pool),
                .sel_byte (sel_k),
                .lane_out (out_k)
            );

            // Put the selected byte back at the same position of the result vector.
            always_comb perm_out[VEC_W-1-k*LANE_W -: LANE_W] = out_k;
        end
    endgenerate
endmodule

// File: rtl/bperm_out_reg.sv
// Output stage: captures the permuted vector on accepted cycles and flags it one cycle later.
// Assumes: synchronous active-low reset; the result holds while no operation is accepted.
module bperm_out_reg #(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [VEC_W-1:0] perm_in,
    output logic [VEC_W-1:0] result,
    output logic             out_valid
);
    // Register the result and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result    <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= perm_in;
            end
        end
    end
endmodule

// File: rtl/byte_permute_unit.sv
// Two-source vector byte permute: each result byte is any of the 32 source bytes, chosen by sel_vec.
// Assumes: one cycle of latency, result held while in_valid is low.
module byte_permute_unit
    import bperm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    input  logic [VEC_W-1:0] sel_vec,
    input  logic             in_valid,
    output logic [VEC_W-1:0] result,
    output logic             out_valid
);
    logic [VEC_W-1:0] perm_next;

    bperm_xbar #(
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) xbar_i (
        .src_a    (src_a),
        .src_b    (src_b),
        .sel_vec  (sel_vec),
        .perm_out (perm_next)
    );

    bperm_out_reg #(
        .VEC_W (VEC_W)
    ) oreg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .perm_in   (perm_next),
        .result    (result),
        .out_valid (out_valid)
    );
endmodule

// File: rtl/bperm_chk.sv
// Checker for the byte permute unit: timing of the valid flag, holding, identity and broadcast.
// Assumes: attached with the bind statement at the bottom of this file.
module bperm_chk
    import bperm_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [VEC_W-1:0] src_a,
    input logic [VEC_W-1:0] sel_vec,
    input logic             in_valid,
    input logic [VEC_W-1:0] result,
    input logic             out_valid
);
    logic             sel_is_ident;
    logic             sel_is_zero;
    logic [VEC_W-1:0] a0_spread;

    // Classify the selector vector and build the byte-0 broadcast of src_a.
    always_comb begin
        sel_is_ident = 1'b1;
        sel_is_zero  = 1'b1;
        for (int p = 0; p < LANES; p++) begin
            if (sel_vec[VEC_W-1-p*LANE_W-(LANE_W-IDX_W) -: IDX_W] != IDX_W'(p)) sel_is_ident = 1'b0;
            if (sel_vec[VEC_W-1-p*LANE_W-(LANE_W-IDX_W) -: IDX_W] != '0)        sel_is_zero  = 1'b0;
            a0_spread[VEC_W-1-p*LANE_W -: LANE_W] = src_a[VEC_W-1 -: LANE_W];
        end
    end

    // R2: an accepted operation is flagged in the next cycle.
    p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2: no flag without an accepted operation.
    p_idle_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R7: result holds across idle cycles.
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    // R6: identity selector returns src_a.
    p_identity_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sel_is_ident) |=> (result == $past(src_a)));

    // R8: an all-zero selector broadcasts byte 0 of src_a.
    p_broadcast_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sel_is_zero) |=> (result == $past(a0_spread)));
endmodule

bind byte_permute_unit bperm_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_a     (src_a),
    .sel_vec   (sel_vec),
    .in_valid  (in_valid),
    .result    (result),
    .out_valid (out_valid)
);

// File: tb/byte_permute_unit_tb_top.sv
// Bench for the byte permute unit: selector sweeps against an arithmetic reference.
module byte_permute_unit_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] src_a = '0;
    logic [127:0] src_b = '0;
    logic [127:0] sel_vec = '0;
    logic         in_valid = 1'b0;
    logic [127:0] result;
    logic         out_valid;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    byte_permute_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_a     (src_a),
        .src_b     (src_b),
        .sel_vec   (sel_vec),
        .in_valid  (in_valid),
        .result    (result),
        .out_valid (out_valid)
    );

    always #5 clk = ~clk;

    function automatic logic [7:0] get_byte(input logic [127:0] v, input int p);
        return v[127-8*p -: 8];
    endfunction

    function automatic logic [127:0] ref_perm(input logic [127:0] a, input logic [127:0] b,
                                              input logic [127:0] c);
        logic [127:0] r;
        int v;
        for (int p = 0; p < 16; p++) begin
            v = int'(get_byte(c, p) & 8'h1f);
            r[127-8*p -: 8] = (v < 16) ? get_byte(a, v) : get_byte(b, v - 16);
        end
        return r;
    endfunction

    function automatic logic [127:0] mk_a(input int s);
        logic [127:0] r;
        for (int k = 0; k < 16; k++) r[127-8*k -: 8] = 8'((k * 37 + s * 11 + 5) & 255);
        return r;
    endfunction

    function automatic logic [127:0] mk_b(input int s);
        logic [127:0] r;
        for (int k = 0; k < 16; k++) r[127-8*k -: 8] = 8'(((k * 53 + s * 7 + 200) & 255) ^ 8'h5a);
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one operation at a falling edge and check it at the next falling edge.
    task automatic run_case(input logic [127:0] a, input logic [127:0] b, input logic [127:0] c,
                            input string req);
        logic [127:0] exp;
        exp = ref_perm(a, b, c);
        @(negedge clk);
        src_a = a; src_b = b; sel_vec = c; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(result == exp, req, result, exp);
        check(out_valid == 1'b1, "R2 out_valid after accept", {127'd0, out_valid}, 128'd1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R2 actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        logic [127:0] c;
        logic [127:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state while reset is held and after release
        check(result == '0, "R1 result in reset", result, '0);
        check(out_valid == 1'b0, "R1 out_valid in reset", {127'd0, out_valid}, '0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(result == '0, "R1 result after release", result, '0);
        check(out_valid == 1'b0, "R1 out_valid after release", {127'd0, out_valid}, '0);

        // R3 R4 R8: broadcast of every selector value
        for (int v = 0; v < 32; v++) begin
            for (int p = 0; p < 16; p++) c[127-8*p -: 8] = 8'(v);
            run_case(mk_a(v), mk_b(v), c, (v < 16) ? "R3 R8 broadcast from A" : "R4 R8 broadcast from B");
        end

        // R3 R4 R8: rotated selectors, every position sees every value
        for (int s = 0; s < 32; s++) begin
            for (int p = 0; p < 16; p++) c[127-8*p -: 8] = 8'((p * 3 + s) % 32);
            run_case(mk_a(s + 40), mk_b(s + 40), c, "R8 rotated selector");
        end

        // R6: identity with clean and noisy upper selector bits
        for (int p = 0; p < 16; p++) c[127-8*p -: 8] = 8'(p);
        run_case(mk_a(90), mk_b(90), c, "R6 identity");
        check(result == mk_a(90), "R6 identity equals src_a", result, mk_a(90));
        for (int p = 0; p < 16; p++) c[127-8*p -: 8] = 8'(p) | 8'((p * 5 + 1) << 5);
        run_case(mk_a(91), mk_b(91), c, "R5 identity with upper bits");
        check(result == mk_a(91), "R5 upper bits ignored", result, mk_a(91));

        // R9: byte interleave of the first halves
        for (int p = 0; p < 16; p++) c[127-8*p -: 8] = (p % 2 == 0) ? 8'(p / 2) : 8'(16 + p / 2);
        run_case(mk_a(92), mk_b(92), c, "R9 interleave");
        check(get_byte(result, 1) == get_byte(mk_b(92), 0), "R9 interleave byte1 is B0",
              {120'd0, get_byte(result, 1)}, {120'd0, get_byte(mk_b(92), 0)});
        for (int p = 0; p < 16; p++) c[127-8*p -: 8] = (p % 2 == 0) ? 8'(p / 2) | 8'he0 : 8'(16 + p / 2) | 8'ha0;
        run_case(mk_a(92), mk_b(92), c, "R5 R9 interleave with upper bits");

        // R9: half/half merge
        for (int p = 0; p < 16; p++) c[127-8*p -: 8] = (p < 8) ? 8'(p) : 8'(16 + p);
        run_case(mk_a(93), mk_b(93), c, "R9 merge");
        check(result == {mk_a(93)[127:64], mk_b(93)[63:0]}, "R9 merge halves", result,
              {mk_a(93)[127:64], mk_b(93)[63:0]});

        // R7: idle cycle with changed operands keeps the result
        held = result;
        @(negedge clk);
        src_a = ~src_a; src_b = ~src_b; sel_vec = 128'h0f0e0d0c0b0a09080706050403020100;
        @(negedge clk);
        check(result == held, "R7 hold while idle", result, held);
        check(out_valid == 1'b0, "R2 out_valid drops when idle", {127'd0, out_valid}, '0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule